// File: doc/BRIEF.md
# Combined Gate and Coincidence Pattern Unit

This block watches eight input levels and produces two kinds of result. First, four combined gate outputs, each the logical OR of two product terms; a product term is an 8-bit mask that is met when every input it selects is high. The eight mask bytes arrive packed in two 32-bit configuration words, and the gates follow the inputs with no register in the path.

Second, it keeps one 8-bit coincidence pattern. A pattern gate level opens a capture window. While the window is open, the unit collects which inputs were high. When the window closes, the pattern is frozen and later windows are refused until the pattern is cleared. Three clear sources can empty and re-arm it: a selected clear strobe, a bus clear strobe, and a master reset strobe that acts only when its enable bit is set.

Top module: `coinc_unit`

## Requirements
- R1: Combined gate n (`cg_out[n]`) is high in the same cycle as the inputs whenever either of its two terms is met. A term is met when its mask is nonzero and every input bit set in the mask is high.
- R2: A term whose mask is all zeros is never met, so a gate whose two masks are both zero stays low even when all inputs are high.
- R3: Mask packing. In `mask_a`, gate 0 takes its terms from bits 7:0 and 15:8, and gate 1 from bits 23:16 and 31:24. In `mask_b`, gate 2 takes bits 7:0 and 15:8, and gate 3 takes bits 23:16 and 31:24.
- R4: When the pattern is empty, a rising edge of `pat_gate` opens a window. After each clock edge at which `pat_gate` is high inside the window, `pattern` holds the OR of the inputs sampled at those edges. The update appears after the edge.
- R5: At the first clock edge with `pat_gate` low, the window closes. From then on the pattern keeps its value and ignores any further gate windows until a clear.
- R6: A `sel_clr` pulse empties `pattern` to zero at the next edge and re-arms capture.
- R7: A `bus_clr` pulse empties `pattern` to zero at the next edge and re-arms capture.
- R8: A `mrst` pulse empties the pattern only when `mrst_en` is 1. With `mrst_en` at 0 it has no effect.
- R9: A clear wins over a gate rising edge in the same cycle. That gate window is not recorded, even if the gate stays high afterwards.
- R10: A synchronous active-high `rst` empties the pattern and the capture state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lvl | input | 8 | Input levels |
| mask_a | input | 32 | Term masks for gates 0 and 1 |
| mask_b | input | 32 | Term masks for gates 2 and 3 |
| pat_gate | input | 1 | Pattern capture window level |
| sel_clr | input | 1 | Selected clear strobe |
| bus_clr | input | 1 | Bus clear strobe |
| mrst | input | 1 | Master reset strobe |
| mrst_en | input | 1 | Enables master reset on the pattern |
| cg_out | output | 4 | Combined gate outputs |
| pattern | output | 8 | Coincidence pattern |

## Verification
Some properties are checked on every cycle by the assertions:
- an all-zero term pair keeps its gate low;
- any enabled clear empties the pattern at the next edge;
- a held pattern stays stable while no clear arrives;
- the pattern only gains bits while a window is open;
- the empty state always shows a zero pattern.

Other behaviours can only be shown by the directed scenarios:
- the exact packing of the mask bytes;
- which inputs accumulate over a multi-cycle window;
- the refusal of a second window;
- the master reset with and without its enable;
- a clear colliding with a gate rising edge.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    localparam int IN_W   = 8;
    localparam int MREG_W = 32;
    localparam int TERM_N = 2;

    typedef enum logic [1:0] {
        PH_EMPTY = 2'd0,
        PH_OPEN  = 2'd1,
        PH_HELD  = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic any_clr;
        logic gate_rise;
        logic gate_lvl;
    } hold_ctrl_t;

    function automatic logic term_met(input logic [IN_W-1:0] msk,
                                      input logic [IN_W-1:0] lvl);
        return (msk != '0) && ((lvl & msk) == msk);
    endfunction

endpackage

// File: rtl/cg_term.sv
module cg_term
    import coinc_pkg::*;
(
    input  logic [IN_W-1:0] msk,
    input  logic [IN_W-1:0] lvl,
    output logic            hit
);
    always_comb hit = term_met(msk, lvl);
endmodule

// File: rtl/cg_bank.sv
module cg_bank
    import coinc_pkg::*;
#(
    parameter int GATES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GATES*TERM_N*IN_W-1:0] masks,
    input  logic [IN_W-1:0]          lvl,
    output logic [GATES-1:0]         cg
);
    localparam int GATE_BITS = TERM_N * IN_W;

    for (genvar g = 0; g < GATES; g++) begin : g_gate
        logic [TERM_N-1:0] hits;
        for (genvar t = 0; t < TERM_N; t++) begin : g_term
            cg_term u_term (
                .msk (masks[g*GATE_BITS + t*IN_W +: IN_W]),
                .lvl (lvl),
                .hit (hits[t])
            );
        end
        always_comb cg[g] = |hits;

        AST_ZERO_TERMS_LOW: assert property (@(posedge clk) disable iff (rst)
            (masks[g*GATE_BITS +: GATE_BITS] == '0) |-> !cg[g]); // R2
    end
endmodule

// File: rtl/pattern_hold.sv
module pattern_hold
    import coinc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  hold_ctrl_t      ctrl,
    input  logic [IN_W-1:0] lvl,
    output logic [IN_W-1:0] pat
);
    hold_state_e state_q, state_d;
    logic [IN_W-1:0] pat_d;

    always_comb begin
        state_d = state_q;
        pat_d   = pat;
        if (ctrl.any_clr) begin
            state_d = PH_EMPTY;
            pat_d   = '0;
        end else begin
            unique case (state_q)
                PH_EMPTY: if (ctrl.gate_rise) begin
                    state_d = PH_OPEN;
                    pat_d   = lvl;
                end
                PH_OPEN: if (ctrl.gate_lvl) pat_d = pat | lvl;
                         else               state_d = PH_HELD;
                PH_HELD: ;
                default: state_d = PH_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_EMPTY;
            pat     <= '0;
        end else begin
            state_q <= state_d;
            pat     <= pat_d;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        ctrl.any_clr |=> (pat == '0)); // R6
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HELD && !ctrl.any_clr) |=> $stable(pat)); // R5
    AST_OPEN_GROWS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_OPEN && !ctrl.any_clr) |=> ((pat & $past(pat)) == $past(pat))); // R4
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_EMPTY) |-> (pat == '0)); // R10
endmodule

// File: rtl/coinc_unit.sv
module coinc_unit
    import coinc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   in_lvl,
    input  logic [MREG_W-1:0] mask_a,
    input  logic [MREG_W-1:0] mask_b,
    input  logic              pat_gate,
    input  logic              sel_clr,
    input  logic              bus_clr,
    input  logic              mrst,
    input  logic              mrst_en,
    output logic [3:0]        cg_out,
    output logic [IN_W-1:0]   pattern
);
    localparam int GATES = (2 * MREG_W) / (TERM_N * IN_W);

    logic       gate_q;
    hold_ctrl_t ctrl;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= pat_gate;
    end

    always_comb begin
        ctrl.any_clr   = sel_clr | bus_clr | (mrst & mrst_en);
        ctrl.gate_rise = pat_gate & ~gate_q;
        ctrl.gate_lvl  = pat_gate;
    end

    cg_bank #(.GATES(GATES)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .masks ({mask_b, mask_a}),
        .lvl   (in_lvl),
        .cg    (cg_out)
    );

    pattern_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .lvl  (in_lvl),
        .pat  (pattern)
    );

    AST_MRST_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mrst && !mrst_en && !sel_clr && !bus_clr && !pat_gate && !gate_q && pattern != '0)
        |=> $stable(pattern)); // R8
endmodule

// File: tb/coinc_unit_test.sv
module coinc_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  in_lvl;
    logic [31:0] mask_a, mask_b;
    logic        pat_gate, sel_clr, bus_clr, mrst, mrst_en;
    logic [3:0]  cg_out;
    logic [7:0]  pattern;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coinc_unit uut (
        .clk(clk), .rst(rst), .in_lvl(in_lvl), .mask_a(mask_a), .mask_b(mask_b),
        .pat_gate(pat_gate), .sel_clr(sel_clr), .bus_clr(bus_clr),
        .mrst(mrst), .mrst_en(mrst_en), .cg_out(cg_out), .pattern(pattern)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_lvl = 8'h00; pat_gate = 0; sel_clr = 0; bus_clr = 0; mrst = 0; mrst_en = 0;
    endtask

    // capture a window: inputs a then b while the gate is high, then close
    task automatic capture(input logic [7:0] a, input logic [7:0] b);
        pat_gate = 1; in_lvl = a; tick();
        in_lvl = b; tick();
        pat_gate = 0; in_lvl = 8'hFF; tick();
        in_lvl = 8'h00;
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); mask_a = '0; mask_b = '0;
        tick(); tick();
        rst = 0;
        tick();
        chk("R10 reset pattern", pattern, 8'h00);
        in_lvl = 8'hFF; #1;
        chk("R2 zero masks", cg_out, 4'h0);
        in_lvl = 8'h00;
    endtask

    task automatic t_gates();
        mask_a = 32'h0000_0003; mask_b = '0;
        in_lvl = 8'h03; #1; chk("R1 term met", cg_out, 4'b0001);
        in_lvl = 8'h01; #1; chk("R1 term partial", cg_out, 4'b0000);
        mask_a = 32'h0000_F003;
        in_lvl = 8'hF0; #1; chk("R1 second term", cg_out, 4'b0001);
        mask_a = 32'h0081_0000;
        in_lvl = 8'h81; #1; chk("R3 gate1 low byte", cg_out, 4'b0010);
        mask_a = '0; mask_b = 32'h2200_0000;
        in_lvl = 8'h22; #1; chk("R3 gate3 top byte", cg_out, 4'b1000);
        mask_b = 32'h0000_0400;
        in_lvl = 8'h04; #1; chk("R3 gate2 byte1", cg_out, 4'b0100);
        mask_b = 32'h0000_0004;
        in_lvl = 8'hFF; #1; chk("R2 zero term other", cg_out, 4'b0100);
        mask_a = '0; mask_b = '0; in_lvl = 8'h00; tick();
    endtask

    task automatic t_capture();
        pat_gate = 1; in_lvl = 8'h01; tick();
        chk("R4 first edge", pattern, 8'h01);
        in_lvl = 8'h04; tick();
        chk("R4 accumulate", pattern, 8'h05);
        pat_gate = 0; in_lvl = 8'h80; tick();
        chk("R5 closed", pattern, 8'h05);
        capture(8'hFF, 8'hFF);
        chk("R5 second window ignored", pattern, 8'h05);
    endtask

    task automatic t_clears();
        sel_clr = 1; tick(); sel_clr = 0;
        chk("R6 sel_clr", pattern, 8'h00);
        capture(8'h10, 8'h00);
        chk("R6 rearmed", pattern, 8'h10);
        bus_clr = 1; tick(); bus_clr = 0;
        chk("R7 bus_clr", pattern, 8'h00);
        capture(8'h20, 8'h08);
        chk("R7 rearmed", pattern, 8'h28);
        mrst = 1; mrst_en = 0; tick(); mrst = 0;
        chk("R8 mrst disabled", pattern, 8'h28);
        mrst = 1; mrst_en = 1; tick(); mrst = 0; mrst_en = 0;
        chk("R8 mrst enabled", pattern, 8'h00);
    endtask

    task automatic t_priority();
        pat_gate = 1; sel_clr = 1; in_lvl = 8'h40; tick();
        sel_clr = 0;
        chk("R9 clear wins", pattern, 8'h00);
        tick();
        chk("R9 gate still high", pattern, 8'h00);
        pat_gate = 0; tick();
        capture(8'h02, 8'h00);
        chk("R9 next window", pattern, 8'h02);
        rst = 1; tick(); rst = 0;
        chk("R10 reset clears", pattern, 8'h00);
    endtask

    initial begin
        t_reset();
        t_gates();
        t_capture();
        t_clears();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule